// File: doc/BRIEF.md
# Multi-Bus I2C Interrupt Status Aggregator

This block holds the interrupt state of several I2C bus engines that share one interrupt line. Every bus has its own enable register, status register and command register in a 64-byte window of a simple register space. Single-cycle event pulses from a bus engine set status bits. Software clears them by writing ones. One slot of the space holds a controller summary register with one bit per bus, and all summary bits together drive a single interrupt output.

A bus's summary bit is sticky. It rises when that bus has a status bit that is both set and enabled. It falls only when a software write to that bus's status register leaves the status fully zero. A write to the command register never touches status. Only the low fifteen status bits respond to write-one-to-clear.

Address layout: `addr_i[ADDR_W-1:6]` selects the slot and `addr_i[5:0]` selects the byte offset within it. Slot 0 is the controller, and the summary register sits at offset 0x00 with bus b in bit b. Slot b+1 is bus b: enable at 0x0C, status at 0x10, command at 0x14. Reads are combinational from `addr_i`. Writes take effect at the clock edge where `wr_en_i` is high.

Top module: `i2c_irq_agg`

## Requirements
- R1: A synchronous reset clears every status, enable, command and summary register, and `irq_o` reads 0.
- R2: An event pulse in bit i of a bus's event vector sets status bit i at that clock edge when i is 31, 30, 15, 14, 13, 12, 7, 6, 5 or 4. All other positions, including 19:16, read 0 and cannot be set.
- R3: A write to status offset 0x10 clears exactly the status bits within 14:0 whose write-data bit is 1.
- R4: A status write never changes status bits 31, 30 and 15.
- R5: A write to command offset 0x14 stores the full 32-bit value for read-back and leaves every status bit unchanged.
- R6: When an event pulse and a write-one-clear hit the same status bit at the same edge, the bit ends set.
- R7: A bus's summary bit (controller offset 0x00, bit b) becomes 1 at the edge after which its status ANDed with its enable is nonzero. This includes an edge where the enable write and the event coincide.
- R8: A summary bit falls only at a status write that leaves that bus's status at zero. Clearing enables, or a status write that leaves any bit set, keeps it at 1.
- R9: `irq_o` is 1 exactly when at least one summary bit is 1.
- R10: Reading status returns the raw status bits whatever the enable setting is.
- R11: The enable register at offset 0x0C stores only the settable positions of R2 (mask 0xC000F0F0) and reads back masked.
- R12: Writes to the summary register, to unused offsets or to unused slots change nothing, and reads of unused offsets and slots return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address: slot in upper bits, offset in low 6 bits |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| evt_i | input | NUM_BUS*32 | Event pulses, bus b in bits b*32+31 : b*32 |
| irq_o | output | 1 | Shared interrupt line |

## Verification
The bench builds the block with two buses, which gives an 8-bit address and a 2-bit summary register. At that size every one of the 32 event positions and every one of the 32 write-one-clear positions can be swept on both buses, and the status read-back after each step is compared with a mask-based model. Two buses also allow a second bus to hold the shared line high while the other bus's summary is cleared, and after a reset a single bus's clear can be shown to drop the line.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned WIN_BITS = 6;

    // Status positions an event may set
    localparam logic [DATA_W-1:0] STS_SETTABLE = 32'hC000_F0F0;
    // Status positions a write of one may clear
    localparam logic [DATA_W-1:0] STS_W1C      = 32'h0000_7FFF;

    localparam logic [WIN_BITS-1:0] OFF_SUMMARY = 6'h00;
    localparam logic [WIN_BITS-1:0] OFF_ENABLE  = 6'h0C;
    localparam logic [WIN_BITS-1:0] OFF_STATUS  = 6'h10;
    localparam logic [WIN_BITS-1:0] OFF_CMD     = 6'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SUMMARY,
        SEL_ENABLE,
        SEL_STATUS,
        SEL_CMD
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] enable;
        logic [DATA_W-1:0] cmd;
        logic              summary;
    } bus_state_t;

endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int unsigned NUM_BUS = 4,
    localparam int unsigned SLOT_W = $clog2(NUM_BUS + 1),
    localparam int unsigned ADDR_W = SLOT_W + WIN_BITS,
    localparam int unsigned BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [BUS_W-1:0]  bus_o
);

    logic [SLOT_W-1:0]   slot;
    logic [WIN_BITS-1:0] offs;

    assign slot = addr_i[ADDR_W-1:WIN_BITS];
    assign offs = addr_i[WIN_BITS-1:0];

    always_comb begin
        sel_o = SEL_NONE;
        bus_o = '0;
        if (slot == '0) begin
            if (offs == OFF_SUMMARY) begin
                sel_o = SEL_SUMMARY;
            end
        end else if (slot <= SLOT_W'(NUM_BUS)) begin
            bus_o = BUS_W'(slot - SLOT_W'(1));
            unique case (offs)
                OFF_ENABLE: sel_o = SEL_ENABLE;
                OFF_STATUS: sel_o = SEL_STATUS;
                OFF_CMD:    sel_o = SEL_CMD;
                default:    sel_o = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_irq_bus_regs.sv
module i2c_irq_bus_regs
    import i2c_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] evt_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] enable_o,
    output logic [DATA_W-1:0] cmd_o,
    output logic              summary_o
);

    bus_state_t        st_d, st_q;
    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] set_bits;
    logic              sts_wr;

    always_comb begin
        st_d     = st_q;
        sts_wr   = wr_i && (sel_i == SEL_STATUS);
        clr_bits = sts_wr ? (wdata_i & STS_W1C) : '0;
        set_bits = evt_i & STS_SETTABLE;

        // set after clear, so a coincident event wins
        st_d.status = (st_q.status & ~clr_bits) | set_bits;

        if (wr_i && (sel_i == SEL_ENABLE)) begin
            st_d.enable = wdata_i & STS_SETTABLE;
        end
        if (wr_i && (sel_i == SEL_CMD)) begin
            st_d.cmd = wdata_i;
        end

        if ((st_d.status & st_d.enable) != '0) begin
            st_d.summary = 1'b1;
        end else if (sts_wr && (st_d.status == '0)) begin
            st_d.summary = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = st_q.status;
    assign enable_o  = st_q.enable;
    assign cmd_o     = st_q.cmd;
    assign summary_o = st_q.summary;

    assert_unsettable_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o & ~STS_SETTABLE) == '0);

    assert_high_bits_kept_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i |=> (($past(status_o) & ~STS_W1C & ~status_o) == '0));

    assert_no_clear_without_sts_write_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_i && (sel_i == SEL_STATUS)) |=> (($past(status_o) & ~status_o) == '0));

    assert_event_wins_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ((evt_i & STS_SETTABLE) != '0) |=>
            ((status_o & $past(evt_i & STS_SETTABLE)) == $past(evt_i & STS_SETTABLE)));

    assert_summary_falls_on_sts_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(summary_o) |-> ($past(wr_i && (sel_i == SEL_STATUS)) && (status_o == '0)));

endmodule

// File: rtl/i2c_irq_rdmux.sv
module i2c_irq_rdmux
    import i2c_irq_pkg::*;
#(
    parameter int unsigned NUM_BUS = 4,
    localparam int unsigned BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  reg_sel_e                        sel_i,
    input  logic [BUS_W-1:0]                bus_i,
    input  logic [NUM_BUS-1:0][DATA_W-1:0]  status_i,
    input  logic [NUM_BUS-1:0][DATA_W-1:0]  enable_i,
    input  logic [NUM_BUS-1:0][DATA_W-1:0]  cmd_i,
    input  logic [NUM_BUS-1:0]              summary_i,
    output logic [DATA_W-1:0]               rdata_o
);

    always_comb begin
        unique case (sel_i)
            SEL_SUMMARY: rdata_o = DATA_W'(summary_i);
            SEL_ENABLE:  rdata_o = enable_i[bus_i];
            SEL_STATUS:  rdata_o = status_i[bus_i];
            SEL_CMD:     rdata_o = cmd_i[bus_i];
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/i2c_irq_agg.sv
module i2c_irq_agg
    import i2c_irq_pkg::*;
#(
    parameter int unsigned NUM_BUS = 4,
    localparam int unsigned ADDR_W = $clog2(NUM_BUS + 1) + WIN_BITS
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rdata_o,
    input  logic [NUM_BUS*DATA_W-1:0] evt_i,
    output logic                      irq_o
);

    localparam int unsigned BUS_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    reg_sel_e                       dec_sel;
    logic [BUS_W-1:0]               dec_bus;
    logic [NUM_BUS-1:0][DATA_W-1:0] status_all;
    logic [NUM_BUS-1:0][DATA_W-1:0] enable_all;
    logic [NUM_BUS-1:0][DATA_W-1:0] cmd_all;
    logic [NUM_BUS-1:0]             summary_all;
    logic                           any_pending;

    i2c_irq_decode #(.NUM_BUS(NUM_BUS)) decode_i (
        .addr_i (addr_i),
        .sel_o  (dec_sel),
        .bus_o  (dec_bus)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        logic bus_wr;
        assign bus_wr = wr_en_i && (dec_bus == BUS_W'(b)) &&
                        (dec_sel != SEL_NONE) && (dec_sel != SEL_SUMMARY);

        i2c_irq_bus_regs bus_regs_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .wr_i      (bus_wr),
            .sel_i     (dec_sel),
            .wdata_i   (wdata_i),
            .evt_i     (evt_i[b*DATA_W +: DATA_W]),
            .status_o  (status_all[b]),
            .enable_o  (enable_all[b]),
            .cmd_o     (cmd_all[b]),
            .summary_o (summary_all[b])
        );
    end

    i2c_irq_rdmux #(.NUM_BUS(NUM_BUS)) rdmux_i (
        .sel_i     (dec_sel),
        .bus_i     (dec_bus),
        .status_i  (status_all),
        .enable_i  (enable_all),
        .cmd_i     (cmd_all),
        .summary_i (summary_all),
        .rdata_o   (rdata_o)
    );

    assign irq_o = |summary_all;

    always_comb begin
        any_pending = 1'b0;
        for (int b = 0; b < NUM_BUS; b++) begin
            any_pending = any_pending | ((status_all[b] & enable_all[b]) != '0);
        end
    end

    // a rising line must come from an enabled, set status bit
    assert_irq_rise_has_cause_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> any_pending);

    // while any enabled status is set, the line stays up
    assert_irq_held_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        any_pending |-> irq_o);

endmodule

// File: tb/i2c_irq_agg_tb_top.sv
module i2c_irq_agg_tb_top;

    localparam int NB = 2;
    localparam int AW = $clog2(NB + 1) + 6;
    localparam logic [31:0] SETTABLE = 32'hC000_F0F0;
    localparam logic [31:0] W1C      = 32'h0000_7FFF;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [AW-1:0]    addr;
    logic [31:0]      wdata;
    logic [31:0]      rdata;
    logic [NB*32-1:0] evt;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_sts [NB];
    logic [31:0] m_en  [NB];
    logic [31:0] m_cmd [NB];
    logic        m_sum [NB];

    always #5 clk = ~clk;

    i2c_irq_agg #(.NUM_BUS(NB)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .evt_i   (evt),
        .irq_o   (irq)
    );

    function automatic logic [AW-1:0] a_of(int slot, int off);
        return AW'(slot * 64 + off);
    endfunction

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
        int slot = int'(a) / 64;
        int off  = int'(a) % 64;
        logic [31:0] r = '0;
        if (slot == 0 && off == 0) begin
            for (int b = 0; b < NB; b++) r[b] = m_sum[b];
        end else if (slot >= 1 && slot <= NB) begin
            if (off == 'h0C) r = m_en[slot-1];
            if (off == 'h10) r = m_sts[slot-1];
            if (off == 'h14) r = m_cmd[slot-1];
        end
        return r;
    endfunction

    task automatic model_step(logic w, logic [AW-1:0] a, logic [31:0] d, logic [NB*32-1:0] e);
        int slot = int'(a) / 64;
        int off  = int'(a) % 64;
        for (int b = 0; b < NB; b++) begin
            logic        hit = w && (slot == b + 1);
            logic [31:0] clr = (hit && off == 'h10) ? (d & W1C) : 32'h0;
            logic [31:0] ns  = (m_sts[b] & ~clr) | (e[b*32 +: 32] & SETTABLE);
            if (hit && off == 'h0C) m_en[b]  = d & SETTABLE;
            if (hit && off == 'h14) m_cmd[b] = d;
            if ((ns & m_en[b]) != 0)                 m_sum[b] = 1'b1;
            else if (hit && off == 'h10 && ns == 0)  m_sum[b] = 1'b0;
            m_sts[b] = ns;
        end
    endtask

    task automatic step(logic w, logic [AW-1:0] a, logic [31:0] d, logic [NB*32-1:0] e);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; evt = e;
        model_step(w, a, d, e);
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(string tag, logic [AW-1:0] a);
        addr = a;
        #1;
        check(tag, rdata, exp_rd(a));
    endtask

    task automatic chk_irq(string tag);
        logic e = 1'b0;
        for (int b = 0; b < NB; b++) e = e | m_sum[b];
        check(tag, {31'b0, irq}, {31'b0, e});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; evt = '0; wdata = '0; addr = '0;
        for (int b = 0; b < NB; b++) begin
            m_sts[b] = '0; m_en[b] = '0; m_cmd[b] = '0; m_sum[b] = 1'b0;
        end
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; evt = '0; wdata = '0; addr = '0;
        do_reset();

        // R1 reset state of every register and the line
        chk_rd("R1", a_of(0, 0));
        for (int b = 0; b < NB; b++) begin
            chk_rd("R1", a_of(b + 1, 'h0C));
            chk_rd("R1", a_of(b + 1, 'h10));
            chk_rd("R1", a_of(b + 1, 'h14));
        end
        chk_irq("R1");

        // R11 enable masking
        for (int b = 0; b < NB; b++) begin
            step(1, a_of(b + 1, 'h0C), 32'hFFFF_FFFF, '0);
            chk_rd("R11", a_of(b + 1, 'h0C));
            step(1, a_of(b + 1, 'h0C), 32'h0, '0);
            chk_rd("R11", a_of(b + 1, 'h0C));
        end

        // R2 / R10 event sweep with enables off
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < 32; i++) begin
                logic [NB*32-1:0] e = '0;
                e[b*32 + i] = 1'b1;
                step(0, '0, '0, e);
                chk_rd("R2", a_of(b + 1, 'h10));
                chk_rd("R10", a_of(0, 0));
            end
            chk_irq("R10");
        end

        // R5 command write leaves status
        for (int b = 0; b < NB; b++) begin
            step(1, a_of(b + 1, 'h14), 32'hA5A5_FFF0 | 32'(b), '0);
            chk_rd("R5", a_of(b + 1, 'h14));
            chk_rd("R5", a_of(b + 1, 'h10));
        end

        // R3 / R4 write-one-clear sweep
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < 32; i++) begin
                step(1, a_of(b + 1, 'h10), 32'h1 << i, '0);
                chk_rd((i <= 14) ? "R3" : "R4", a_of(b + 1, 'h10));
            end
            check("R4", exp_rd(a_of(b + 1, 'h10)), 32'hC000_8000);
        end

        // R12 writes to read-only or unused places
        step(1, a_of(0, 0), 32'hFFFF_FFFF, '0);
        chk_rd("R12", a_of(0, 0));
        step(1, a_of(1, 'h18), 32'hFFFF_FFFF, '0);
        chk_rd("R12", a_of(1, 'h18));
        chk_rd("R12", a_of(1, 'h0C));
        chk_rd("R12", a_of(1, 'h10));
        step(1, a_of(3, 'h0C), 32'hFFFF_FFFF, '0);
        chk_rd("R12", a_of(3, 'h0C));
        chk_rd("R12", a_of(0, 'h04));
        chk_irq("R12");

        // R7 / R8 on bus 0 with uncleared high bits
        step(1, a_of(1, 'h0C), 32'h8000_0000, '0);
        chk_rd("R7", a_of(0, 0));
        chk_irq("R9");
        step(1, a_of(1, 'h0C), 32'h0, '0);
        chk_rd("R8", a_of(0, 0));
        step(1, a_of(1, 'h10), 32'hFFFF_FFFF, '0);
        chk_rd("R8", a_of(0, 0));
        chk_irq("R8");

        do_reset();
        chk_irq("R1");

        // R8 / R9 clear path on bus 1
        step(1, a_of(2, 'h0C), 32'h0000_0030, '0);
        step(0, '0, '0, 64'h0000_0030_0000_0000);
        chk_rd("R7", a_of(0, 0));
        chk_irq("R9");
        step(1, a_of(2, 'h10), 32'h0000_0010, '0);
        chk_rd("R8", a_of(0, 0));
        chk_irq("R8");
        step(1, a_of(2, 'h10), 32'h0000_0020, '0);
        chk_rd("R8", a_of(0, 0));
        chk_rd("R8", a_of(2, 'h10));
        chk_irq("R9");

        // R6 event and clear on the same bit
        step(1, a_of(1, 'h10), 32'hFFFF_FFFF, 64'h0000_0000_0000_0010);
        chk_rd("R6", a_of(1, 'h10));
        chk_irq("R6");

        // R7 enable write and event on the same edge
        step(1, a_of(2, 'h0C), 32'h0000_0040, 64'h0000_0040_0000_0000);
        chk_rd("R7", a_of(0, 0));
        chk_irq("R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule